// File: doc/BRIEF.md
# Synchronous Serial Master with Baud Generator

This block is a full-duplex synchronous serial master. Once a word is written, it drives a serial clock, sends the word one bit at a time on a transmit line and captures the same number of bits from a receive line. A low-active select line frames the transfer. A baud value sets the speed: each half-phase of the serial clock lasts (baud + 1) system clocks, so the serial clock period is 2·(baud + 1) system clocks. A baud value of zero runs at the same speed as one. The clock idle level and the shift/latch edge pair can be programmed. The frame length runs from 2 to 16 bits, and the word can be sent with either end first.

The host sets baud, polarity, phase, bit order, frame length and the phase-error enable with a single configuration strobe. Writing a transmit word starts a frame. The received word appears together with a one-cycle done pulse. When the phase-error check is enabled, the block compares the receive line one system clock before and one system clock after each latch edge. If the two samples differ, a sticky error flag is raised. A clear strobe drops the flag.

Top module: `sync_ser_master`

## Requirements
- R1: After reset, busy and done are 0, the select line is 1, the serial clock is 0, the error flag is 0 and the received word is 0.
- R2: Each serial clock half-phase lasts (B+1) system clocks, where B is the baud value and a value of 0 counts as 1. Busy therefore stays high for exactly 2·N·(B+1) cycles, where N is the frame length in bits.
- R3: While idle, the serial clock rests at the polarity bit, and it follows a polarity change one cycle after the configuration write.
- R4: Transmit data changes only at the start of a bit. Receive data is latched when the clock leaves its active level if the phase bit is 0, and when it enters its active level if the phase bit is 1. With a looped-back receive line, the received word equals the sent bits.
- R5: The frame length field holds N-1. A field value of 0 gives a 2-bit frame. Bits of the received word at and above position N read 0.
- R6: With the order bit at 0, bit N-1 goes out first. With the order bit at 1, bit 0 goes out first. Received bits are placed at the same positions as the bits sent.
- R7: Done is a single-cycle pulse. It rises in the same cycle that busy falls, and the received word is valid from that cycle on.
- R8: With the check enabled, a receive-line change between the sample one clock before a latch edge and the sample one clock after it sets the error flag. The flag stays set until an error-clear strobe.
- R9: With the check disabled, the error flag never sets.
- R10: A transmit write or a configuration write made while busy is ignored. A configuration write made in the same cycle as a transmit write is also ignored.
- R11: The select line is low exactly while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_baud | input | BAUD_W | Baud value B |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Phase: 0 latches on the trailing edge, 1 latches on the leading edge |
| cfg_lsb_first | input | 1 | Bit order: 1 sends bit 0 first |
| cfg_len_m1 | input | LEN_W | Frame length minus one |
| cfg_pe_en | input | 1 | Phase-error check enable |
| wr_tx | input | 1 | Transmit write strobe; starts a frame when idle |
| tx_din | input | DATA_W | Word to send |
| err_clr | input | 1 | Clears the error flag |
| rx_line | input | 1 | Serial receive line |
| sclk | output | 1 | Serial clock |
| tx_line | output | 1 | Serial transmit line |
| sel_n | output | 1 | Low-active frame select |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_data | output | DATA_W | Last received word |
| pe_err | output | 1 | Sticky phase-error flag |

## Verification
The bench uses the default 16-bit data and baud widths. It loops the transmit line back to the receive line, with an optional inversion, so that every bit latched can be predicted. Small baud values (0, 1, 3, 5) keep the frames short, which leaves room for the zero-baud clamp, all four polarity/phase pairs, both bit orders and the 2-bit and 16-bit length limits. The bench can also flip the receive line for one clock right after each latch edge, which triggers the phase-error check on demand.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  // Smallest frame the sequencer will run.
  localparam int SSM_MIN_BITS = 2;

  // Serial clock level during a half-phase. Phase 0: even halves are active.
  function automatic logic ssm_clk_level(input logic pol, input logic ph, input logic odd_half);
    return pol ^ (ph ? odd_half : ~odd_half);
  endfunction
endpackage

// File: rtl/ssm_half_timer.sv
module ssm_half_timer #(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              half_end
);
  logic [BAUD_W-1:0] cnt;
  logic [BAUD_W-1:0] reload;

  // A zero baud value would shorten the period below the minimum.
  assign reload   = (baud == '0) ? BAUD_W'(1) : baud;
  assign half_end = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= reload;
    end else if (run) begin
      cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ssm_phase_chk.sv
module ssm_phase_chk (
  input  logic clk,
  input  logic rst,
  input  logic latch_evt,
  input  logic rx_line,
  input  logic enable,
  input  logic clr,
  output logic err
);
  logic pend;
  logic s_before;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      s_before <= 1'b0;
      err      <= 1'b0;
    end else begin
      pend <= latch_evt & enable;
      if (latch_evt) s_before <= rx_line;
      if (pend && (rx_line != s_before)) err <= 1'b1;
      else if (clr)                       err <= 1'b0;
    end
  end
endmodule

// File: rtl/ssm_seq.sv
module ssm_seq
  import ssm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              half_end,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              lsb_first,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              rx_line,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              tx_line,
  output logic              sel_n,
  output logic              latch_evt,
  output logic [DATA_W-1:0] rx_data
);
  localparam int HW = LEN_W + 1;

  logic [HW-1:0]     half_idx;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [LEN_W-1:0]  last_bit, bit_now, bit_nxt;
  logic [LEN_W-1:0]  pos_now, pos_nxt, pos_first;
  logic              is_last;

  assign last_bit  = (len_m1 < LEN_W'(SSM_MIN_BITS - 1)) ? LEN_W'(SSM_MIN_BITS - 1) : len_m1;
  assign bit_now   = half_idx[HW-1:1];
  assign bit_nxt   = bit_now + 1'b1;
  assign pos_now   = lsb_first ? bit_now : last_bit - bit_now;
  assign pos_nxt   = lsb_first ? bit_nxt : last_bit - bit_nxt;
  assign pos_first = lsb_first ? '0 : last_bit;
  assign is_last   = (half_idx == {last_bit, 1'b1});
  assign latch_evt = busy & half_end & ~half_idx[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      sclk     <= 1'b0;
      tx_line  <= 1'b0;
      sel_n    <= 1'b1;
      half_idx <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rx_data  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        if (start) begin
          busy     <= 1'b1;
          sel_n    <= 1'b0;
          half_idx <= '0;
          tx_q     <= tx_word;
          rx_q     <= '0;
          tx_line  <= tx_word[pos_first];
          sclk     <= ssm_clk_level(cpol, cpha, 1'b0);
        end
      end else if (half_end) begin
        // End of an even half is the latch point in both phase modes.
        if (!half_idx[0]) rx_q[pos_now] <= rx_line;
        if (is_last) begin
          busy    <= 1'b0;
          sel_n   <= 1'b1;
          done    <= 1'b1;
          rx_data <= rx_q;
          sclk    <= cpol;
        end else begin
          half_idx <= half_idx + 1'b1;
          sclk     <= ssm_clk_level(cpol, cpha, ~half_idx[0]);
          if (half_idx[0]) tx_line <= tx_q[pos_nxt];
        end
      end
    end
  end
endmodule

// File: rtl/sync_ser_master.sv
module sync_ser_master #(
  parameter int DATA_W = 16,
  parameter int BAUD_W = 16,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [BAUD_W-1:0] cfg_baud,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              cfg_pe_en,
  input  logic              wr_tx,
  input  logic [DATA_W-1:0] tx_din,
  input  logic              err_clr,
  input  logic              rx_line,
  output logic              sclk,
  output logic              tx_line,
  output logic              sel_n,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              pe_err
);
  logic [BAUD_W-1:0] baud_q;
  logic              cpol_q, cpha_q, lsb_q, pe_en_q;
  logic [LEN_W-1:0]  len_q;
  logic              start, cfg_ok, half_end, latch_evt;

  assign start  = wr_tx & ~busy;
  assign cfg_ok = cfg_we & ~busy & ~wr_tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      baud_q  <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      lsb_q   <= 1'b0;
      pe_en_q <= 1'b0;
      len_q   <= '1;
    end else if (cfg_ok) begin
      baud_q  <= cfg_baud;
      cpol_q  <= cfg_cpol;
      cpha_q  <= cfg_cpha;
      lsb_q   <= cfg_lsb_first;
      pe_en_q <= cfg_pe_en;
      len_q   <= cfg_len_m1;
    end
  end

  ssm_half_timer #(.BAUD_W(BAUD_W)) u_timer (
    .clk(clk), .rst(rst), .load(start), .run(busy), .baud(baud_q), .half_end(half_end)
  );

  ssm_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .half_end(half_end), .tx_word(tx_din),
    .len_m1(len_q), .lsb_first(lsb_q), .cpol(cpol_q), .cpha(cpha_q), .rx_line(rx_line),
    .busy(busy), .done(done), .sclk(sclk), .tx_line(tx_line), .sel_n(sel_n),
    .latch_evt(latch_evt), .rx_data(rx_data)
  );

  ssm_phase_chk u_pchk (
    .clk(clk), .rst(rst), .latch_evt(latch_evt), .rx_line(rx_line),
    .enable(pe_en_q), .clr(err_clr), .err(pe_err)
  );
endmodule

// File: rtl/sync_ser_master_chk.sv
module sync_ser_master_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sel_n,
  input logic tx_line,
  input logic pe_err,
  input logic err_clr,
  input logic cpol_q,
  input logic pe_en_q
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_at_end_r7: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  p_sel_tracks_busy_r11: assert property (@(posedge clk) disable iff (rst) sel_n == !busy);
  p_idle_level_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && $stable(cpol_q)) |-> (sclk == cpol_q));
  p_tx_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(tx_line)) |-> !$stable(sclk));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (pe_err && !err_clr) |=> pe_err);
  p_err_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(pe_err) |-> $past(pe_en_q));
endmodule

bind sync_ser_master sync_ser_master_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .sclk(sclk), .sel_n(sel_n),
  .tx_line(tx_line), .pe_err(pe_err), .err_clr(err_clr), .cpol_q(cpol_q), .pe_en_q(pe_en_q)
);

// File: tb/sync_ser_master_test.sv
module sync_ser_master_test;
  localparam int DATA_W = 16;
  localparam int BAUD_W = 16;
  localparam int LEN_W  = 4;

  typedef struct {
    logic [DATA_W-1:0] rx;
    logic [DATA_W-1:0] ser;
    int                nbits;
    int                cyc;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic              cfg_we = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_pe_en = 0;
  logic [BAUD_W-1:0] cfg_baud = '0;
  logic [LEN_W-1:0]  cfg_len_m1 = '0;
  logic              wr_tx = 0, err_clr = 0;
  logic [DATA_W-1:0] tx_din = '0;
  logic              rx_line, sclk, tx_line, sel_n, busy, done, pe_err;
  logic [DATA_W-1:0] rx_data;

  logic inv_bit = 0, glitch_en = 0, glitch = 0;
  assign rx_line = tx_line ^ inv_bit ^ glitch;

  sync_ser_master #(.DATA_W(DATA_W), .BAUD_W(BAUD_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_baud(cfg_baud), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_len_m1(cfg_len_m1),
    .cfg_pe_en(cfg_pe_en), .wr_tx(wr_tx), .tx_din(tx_din), .err_clr(err_clr),
    .rx_line(rx_line), .sclk(sclk), .tx_line(tx_line), .sel_n(sel_n), .busy(busy),
    .done(done), .rx_data(rx_data), .pe_err(pe_err)
  );

  int n_chk = 0, n_err = 0;
  exp_t exp_q[$];

  // Bench copy of the accepted configuration.
  int cur_br = 0, cur_len = 15;
  logic cur_cpol = 0, cur_cpha = 0, cur_lsb = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  // Monitor and scoreboard.
  int busy_cnt = 0, ser_n = 0;
  logic [DATA_W-1:0] ser_got = '0;
  logic prev_sclk = 0, prev_done = 0, sel_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      glitch <= 1'b0;
      if (busy) begin
        busy_cnt++;
        if (sel_n) sel_bad = 1'b1;
      end
      if (busy && sclk != prev_sclk && sclk == (cur_cpha ? ~cur_cpol : cur_cpol)) begin
        if (ser_n < DATA_W) ser_got[ser_n] = tx_line;
        ser_n++;
        if (glitch_en) glitch <= 1'b1;
      end
      if (prev_done && done) chk("R7 done longer than one cycle", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) begin
          chk("R10 frame with no accepted write", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk("R2 busy length", busy_cnt, e.cyc);
          chk("R5 bits on wire", ser_n, e.nbits);
          chk("R6 wire order", ser_got, e.ser);
          chk("R4 received word", rx_data, e.rx);
          chk("R7 busy low with done", busy, 0);
          chk("R11 select low while busy", {sel_bad, sel_n}, 2'b01);
        end
        busy_cnt = 0; ser_n = 0; ser_got = '0; sel_bad = 1'b0;
      end
      prev_sclk = sclk;
      prev_done = done;
    end
  end

  task automatic config_set(input int br, input logic pol, input logic ph, input logic lsb,
                            input int len_m1, input logic pe);
    @(negedge clk);
    cfg_baud = BAUD_W'(br); cfg_cpol = pol; cfg_cpha = ph; cfg_lsb_first = lsb;
    cfg_len_m1 = LEN_W'(len_m1); cfg_pe_en = pe; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_br = br; cur_cpol = pol; cur_cpha = ph; cur_lsb = lsb; cur_len = len_m1;
  endtask

  task automatic push_exp(input logic [DATA_W-1:0] w);
    exp_t e;
    int n, h;
    n = (cur_len < 1) ? 2 : cur_len + 1;
    h = (cur_br == 0) ? 2 : cur_br + 1;
    e.nbits = n;
    e.cyc   = 2 * n * h;
    e.rx    = '0;
    e.ser   = '0;
    for (int i = 0; i < n; i++) begin
      e.ser[i] = cur_lsb ? w[i] : w[n-1-i];
      e.rx[i]  = w[i] ^ inv_bit;
    end
    exp_q.push_back(e);
  endtask

  task automatic kick(input logic [DATA_W-1:0] w);
    @(negedge clk);
    tx_din = w; wr_tx = 1'b1;
    @(negedge clk);
    wr_tx = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [DATA_W-1:0] w);
    push_exp(w);
    kick(w);
    wait_idle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 sel_n", sel_n, 1);
    chk("R1 sclk", sclk, 0);
    chk("R1 pe_err", pe_err, 0);
    chk("R1 rx_data", rx_data, 0);

    // R2 R4 R6: mode 0, MSB first, 8 bits
    config_set(1, 0, 0, 0, 7, 0);
    send(16'h00A5);
    // R3 R6: pol 1 phase 1, LSB first, inverted loopback
    inv_bit = 1'b1;
    config_set(3, 1, 1, 1, 7, 0);
    send(16'h003C);
    inv_bit = 1'b0;
    // R2 zero baud clamp, 16 bits
    config_set(0, 0, 1, 0, 15, 0);
    send(16'hBEEF);
    // R5 length field 0 gives two bits
    config_set(1, 1, 0, 1, 0, 0);
    send(16'hFFFE);
    // R5 R6 5-bit frame, MSB first
    config_set(5, 0, 0, 0, 4, 0);
    send(16'hFF15);

    // R3 idle level follows polarity
    config_set(1, 1, 0, 0, 7, 0);
    @(negedge clk);
    chk("R3 idle level high", sclk, 1);
    config_set(1, 0, 0, 0, 7, 0);
    @(negedge clk);
    chk("R3 idle level low", sclk, 0);

    // R10 writes while busy are ignored
    push_exp(16'h005A);
    kick(16'h005A);
    repeat (5) @(negedge clk);
    tx_din = 16'hFFFF; wr_tx = 1'b1; cfg_baud = 16'd7; cfg_we = 1'b1;
    @(negedge clk);
    wr_tx = 1'b0; cfg_we = 1'b0;
    wait_idle();
    send(16'h00C3);
    // R10 config together with a transmit write is dropped
    @(negedge clk);
    cfg_baud = 16'd9; cfg_we = 1'b1; tx_din = 16'h0081; wr_tx = 1'b1;
    push_exp(16'h0081);
    @(negedge clk);
    cfg_we = 1'b0; wr_tx = 1'b0;
    wait_idle();
    send(16'h0042);

    // R8 phase error sets, is sticky and clears
    config_set(2, 0, 1, 0, 7, 1);
    glitch_en = 1'b1;
    send(16'h0099);
    chk("R8 error set", pe_err, 1);
    glitch_en = 1'b0;
    send(16'h0066);
    chk("R8 error sticky", pe_err, 1);
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R8 error cleared", pe_err, 0);

    // R9 disabled check never flags
    config_set(2, 1, 0, 0, 7, 0);
    glitch_en = 1'b1;
    send(16'h00F0);
    chk("R9 error stays low", pe_err, 0);
    glitch_en = 1'b0;

    summary();
  end
endmodule